// File: doc/BRIEF.md
# Nibble-to-Dibit Ethernet Pin Adapter

This block sits between a MAC's 4-bit media-independent data path and the pins toward a PHY. A mode input chooses between two pin sets at run time. With the mode low, the classic 4-bit MII pins are wired straight to the MAC side. With the mode high, the reduced pin-count RMII pins are used instead. Transmit nibbles are cut into 2-bit dibits, and received dibits are put back together into nibbles. All RMII logic runs on the 50 MHz reference clock `clk`.

Carrier sense and receive data valid share one RMII input. The receive logic decodes that input. It finds the preamble, aligns nibbles on the start-of-frame delimiter, and keeps data flowing when the PHY signals that carrier is gone but its FIFO still holds data. A rate input picks 100 Mb/s (one dibit per clock) or 10 Mb/s (each dibit lasts `RATE_DIV` clocks).

The MAC transmit side is a valid/ready stream. A nibble moves when `mac_tx_valid` and `mac_tx_ready` are both high at a rising edge. The MAC must then hold the nibble and valid steady until that happens. Receive has no back-pressure, because a PHY cannot be stalled. `mac_rx_valid` is a strobe that is high for one cycle per nibble, and the MAC must take the nibble in that cycle.

Top module: `mii_rmii_bridge`

## Requirements
- R1: With `cfg_rmii`=0, the MII pins are connected straight through in the same cycle. `mii_txd`/`mii_tx_en`/`mii_tx_er` follow `mac_tx_data`/`mac_tx_valid`/`mac_tx_er`. `mac_rx_data`/`mac_rx_valid`/`mac_rx_er`/`mac_crs`/`mac_col` follow `mii_rxd`/`mii_rx_dv`/`mii_rx_er`/`mii_crs`/`mii_col`. `mac_tx_ready` is 1.
- R2: With `cfg_rmii`=1, an accepted nibble goes out on `rmii_txd` as bits [1:0] first, in the period after the accepting edge, and then as bits [3:2]. `rmii_tx_en` stays high for both dibits.
- R3: In RMII mode, `mac_tx_ready` is high only at the start of a dibit period when no high dibit is still waiting to be sent. It is therefore low in the cycle after an accept, and a nibble that is held waiting is never lost or repeated.
- R4: With `cfg_10m`=1, every transmit dibit is held for exactly `RATE_DIV`=10 clocks, and every receive dibit is sampled once per 10 clocks. With `cfg_10m`=0, both happen once per clock.
- R5: The receiver stays idle until `rmii_crs_dv`=1 with dibit 2'b01. It then waits for the first 2'b11 dibit. The dibit after that is bits [1:0] of the first nibble, and the next dibit is bits [3:2]. Each complete nibble produces a single one-cycle `mac_rx_valid` strobe.
- R6: `mac_crs` follows `rmii_crs_dv` while idle or in preamble. In a frame, `mac_crs` follows the value sampled with the low dibit, so a toggling pin (low on the low dibit, high on the high dibit) drops `mac_crs` while nibbles still arrive. The frame ends, with no strobe, when both samples of a nibble period are low, and `mac_crs` is then 0.
- R7: In RMII mode, `mac_col`, `mii_tx_er`, `mii_tx_en` and `mii_txd` are 0 and `mac_tx_er` has no effect. `rmii_rx_er` seen on either dibit of a nibble sets `mac_rx_er` with that nibble.
- R8: In RMII mode, `rmii_tx_en` and `rmii_txd` go to 0 at the first dibit period in which no nibble is waiting.
- R9: After reset in RMII mode, `rmii_tx_en`, `mac_rx_valid` and `mac_crs` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rmii | input | 1 | 1 selects RMII pins, 0 selects MII pass-through |
| cfg_10m | input | 1 | 1 selects 10 Mb/s dibit pacing |
| mac_tx_valid | input | 1 | Transmit nibble valid |
| mac_tx_ready | output | 1 | Transmit nibble accepted this edge |
| mac_tx_data | input | 4 | Transmit nibble |
| mac_tx_er | input | 1 | Transmit error from MAC |
| mac_rx_valid | output | 1 | Receive nibble strobe (RMII) / data valid (MII) |
| mac_rx_data | output | 4 | Receive nibble |
| mac_rx_er | output | 1 | Receive error |
| mac_crs | output | 1 | Carrier sense to MAC |
| mac_col | output | 1 | Collision to MAC |
| mii_txd | output | 4 | MII transmit data |
| mii_tx_en | output | 1 | MII transmit enable |
| mii_tx_er | output | 1 | MII transmit error |
| mii_rxd | input | 4 | MII receive data |
| mii_rx_dv | input | 1 | MII receive data valid |
| mii_rx_er | input | 1 | MII receive error |
| mii_crs | input | 1 | MII carrier sense |
| mii_col | input | 1 | MII collision |
| rmii_txd | output | 2 | RMII transmit dibit |
| rmii_tx_en | output | 1 | RMII transmit enable |
| rmii_rxd | input | 2 | RMII receive dibit |
| rmii_crs_dv | input | 1 | RMII combined carrier sense / data valid |
| rmii_rx_er | input | 1 | RMII receive error |

## Verification
The hardest case to reach from the ports is the end of a frame. There, the combined pin alternates between dibits while nibbles keep arriving, and only a full nibble period with the pin low ends the frame. The receive driver builds this case on purpose. It first sends a preamble and delimiter so the nibble phase is known. It then drives the pin low on the low dibit and high on the high dibit for two nibbles, and the scoreboard expects those nibbles with carrier sense dropped. The frame is then closed with two low dibits, and any extra strobe is flagged. A false carrier with no 2'b01 dibit is also sent, to show that no nibble comes out.

// File: rtl/mii_rmii_pkg.sv
package mii_rmii_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_PRE  = 2'd1,
    RX_DATA = 2'd2
  } rx_state_e;

  localparam logic [1:0] DIBIT_PREAMBLE = 2'b01;
  localparam logic [1:0] DIBIT_SFD_END  = 2'b11;
endpackage

// File: rtl/rmii_rate_tick.sv
module rmii_rate_tick #(
  parameter int RATE_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic slow,
  output logic tick
);
  localparam int CW = (RATE_DIV > 1) ? $clog2(RATE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATE_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !slow) cnt <= '0;
    else if (cnt == LAST)       cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign tick = !slow || (cnt == '0);
endmodule

// File: rtl/rmii_tx_split.sv
module rmii_tx_split (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       in_valid,
  input  logic [3:0] in_data,
  output logic       in_ready,
  output logic [1:0] txd,
  output logic       tx_en
);
  logic       pend;
  logic [1:0] hi_q;
  logic [1:0] txd_q;
  logic       en_q;

  assign in_ready = tick && !pend && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pend  <= 1'b0;
      hi_q  <= '0;
      txd_q <= '0;
      en_q  <= 1'b0;
    end else if (tick) begin
      if (pend) begin
        txd_q <= hi_q;
        pend  <= 1'b0;
      end else if (in_valid) begin
        txd_q <= in_data[1:0];
        hi_q  <= in_data[3:2];
        pend  <= 1'b1;
        en_q  <= 1'b1;
      end else begin
        txd_q <= '0;
        en_q  <= 1'b0;
      end
    end
  end

  assign txd   = txd_q;
  assign tx_en = en_q;
endmodule

// File: rtl/rmii_rx_merge.sv
module rmii_rx_merge
  import mii_rmii_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       crs_dv,
  input  logic [1:0] rxd,
  input  logic       rx_er,
  output logic       nib_valid,
  output logic [3:0] nib,
  output logic       nib_err,
  output logic       crs
);
  rx_state_e  state;
  logic       half;
  logic [1:0] lo_d;
  logic       lo_c;
  logic       lo_er;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      state     <= RX_IDLE;
      half      <= 1'b0;
      lo_d      <= '0;
      lo_c      <= 1'b0;
      lo_er     <= 1'b0;
      nib_valid <= 1'b0;
      nib       <= '0;
      nib_err   <= 1'b0;
      crs       <= 1'b0;
    end else begin
      nib_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            crs <= crs_dv;
            if (crs_dv && rxd == DIBIT_PREAMBLE) state <= RX_PRE;
          end
          RX_PRE: begin
            crs <= crs_dv;
            if (!crs_dv) state <= RX_IDLE;
            else if (rxd == DIBIT_SFD_END) begin
              state <= RX_DATA;
              half  <= 1'b0;
            end
          end
          RX_DATA: begin
            if (!half) begin
              lo_d  <= rxd;
              lo_c  <= crs_dv;
              lo_er <= rx_er;
              crs   <= crs_dv;
              half  <= 1'b1;
            end else begin
              half <= 1'b0;
              if (!crs_dv && !lo_c) begin
                state <= RX_IDLE;
                crs   <= 1'b0;
              end else begin
                nib_valid <= 1'b1;
                nib       <= {rxd, lo_d};
                nib_err   <= rx_er | lo_er;
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mii_rmii_bridge.sv
module mii_rmii_bridge #(
  parameter int RATE_DIV = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_rmii,
  input  logic       cfg_10m,
  input  logic       mac_tx_valid,
  output logic       mac_tx_ready,
  input  logic [3:0] mac_tx_data,
  input  logic       mac_tx_er,
  output logic       mac_rx_valid,
  output logic [3:0] mac_rx_data,
  output logic       mac_rx_er,
  output logic       mac_crs,
  output logic       mac_col,
  output logic [3:0] mii_txd,
  output logic       mii_tx_en,
  output logic       mii_tx_er,
  input  logic [3:0] mii_rxd,
  input  logic       mii_rx_dv,
  input  logic       mii_rx_er,
  input  logic       mii_crs,
  input  logic       mii_col,
  output logic [1:0] rmii_txd,
  output logic       rmii_tx_en,
  input  logic [1:0] rmii_rxd,
  input  logic       rmii_crs_dv,
  input  logic       rmii_rx_er
);
  logic       clr;
  logic       tick;
  logic       sp_ready;
  logic       mg_valid;
  logic [3:0] mg_nib;
  logic       mg_err;
  logic       mg_crs;

  assign clr = !cfg_rmii;

  rmii_rate_tick #(.RATE_DIV(RATE_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(clr), .slow(cfg_10m), .tick(tick)
  );

  rmii_tx_split u_split (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
    .in_valid(mac_tx_valid), .in_data(mac_tx_data), .in_ready(sp_ready),
    .txd(rmii_txd), .tx_en(rmii_tx_en)
  );

  rmii_rx_merge u_merge (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
    .crs_dv(rmii_crs_dv), .rxd(rmii_rxd), .rx_er(rmii_rx_er),
    .nib_valid(mg_valid), .nib(mg_nib), .nib_err(mg_err), .crs(mg_crs)
  );

  always_comb begin
    if (cfg_rmii) begin
      mac_tx_ready = sp_ready;
      mii_txd      = '0;
      mii_tx_en    = 1'b0;
      mii_tx_er    = 1'b0;
      mac_rx_valid = mg_valid;
      mac_rx_data  = mg_nib;
      mac_rx_er    = mg_err;
      mac_crs      = mg_crs;
      mac_col      = 1'b0;
    end else begin
      mac_tx_ready = 1'b1;
      mii_txd      = mac_tx_data;
      mii_tx_en    = mac_tx_valid;
      mii_tx_er    = mac_tx_er;
      mac_rx_valid = mii_rx_dv;
      mac_rx_data  = mii_rxd;
      mac_rx_er    = mii_rx_er;
      mac_crs      = mii_crs;
      mac_col      = mii_col;
    end
  end
endmodule

// File: rtl/mii_rmii_bridge_chk.sv
module mii_rmii_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_rmii,
  input logic       mac_tx_valid,
  input logic       mac_tx_ready,
  input logic [3:0] mac_tx_data,
  input logic       mac_rx_valid,
  input logic       mac_col,
  input logic       mii_tx_en,
  input logic       mii_tx_er,
  input logic [1:0] rmii_txd,
  input logic       rmii_tx_en
);
  a_r2_low_dibit_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rmii && mac_tx_valid && mac_tx_ready) |=>
      (!cfg_rmii || (rmii_tx_en && rmii_txd == $past(mac_tx_data[1:0]))));

  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rmii && mac_tx_valid && mac_tx_ready) |=> !(cfg_rmii && mac_tx_ready));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rmii && mac_rx_valid) |=> !(cfg_rmii && mac_rx_valid));

  a_r7_mii_side_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rmii |-> (!mac_col && !mii_tx_er && !mii_tx_en));
endmodule

bind mii_rmii_bridge mii_rmii_bridge_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rmii(cfg_rmii),
  .mac_tx_valid(mac_tx_valid), .mac_tx_ready(mac_tx_ready),
  .mac_tx_data(mac_tx_data), .mac_rx_valid(mac_rx_valid),
  .mac_col(mac_col), .mii_tx_en(mii_tx_en), .mii_tx_er(mii_tx_er),
  .rmii_txd(rmii_txd), .rmii_tx_en(rmii_tx_en)
);

// File: tb/test_mii_rmii_bridge.sv
module test_mii_rmii_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_rmii = 1'b1;
  logic       cfg_10m = 1'b0;
  logic       mac_tx_valid = 1'b0;
  logic       mac_tx_ready;
  logic [3:0] mac_tx_data = '0;
  logic       mac_tx_er = 1'b0;
  logic       mac_rx_valid;
  logic [3:0] mac_rx_data;
  logic       mac_rx_er;
  logic       mac_crs;
  logic       mac_col;
  logic [3:0] mii_txd;
  logic       mii_tx_en;
  logic       mii_tx_er;
  logic [3:0] mii_rxd = '0;
  logic       mii_rx_dv = 1'b0;
  logic       mii_rx_er = 1'b0;
  logic       mii_crs = 1'b0;
  logic       mii_col = 1'b0;
  logic [1:0] rmii_txd;
  logic       rmii_tx_en;
  logic [1:0] rmii_rxd = '0;
  logic       rmii_crs_dv = 1'b0;
  logic       rmii_rx_er = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [1:0] txq[$];
  logic [5:0] rxq[$];

  always #2 clk = ~clk;

  mii_rmii_bridge i_mii_rmii_bridge (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rate();
    return cfg_10m ? 10 : 1;
  endfunction

  // transmit scoreboard monitor (R2, R4, R8)
  always @(negedge clk) begin
    if (rst_n && cfg_rmii && rmii_tx_en) begin
      if (txq.size() == 0) chk(1'b0, "R8 unexpected tx_en", 1, 0);
      else begin
        logic [1:0] e;
        e = txq.pop_front();
        chk(rmii_txd == e, "R2/R4 tx dibit", rmii_txd, e);
      end
    end
  end

  // receive scoreboard monitor (R5, R6, R7)
  always @(negedge clk) begin
    if (rst_n && cfg_rmii && mac_rx_valid) begin
      if (rxq.size() == 0) chk(1'b0, "R5 unexpected rx strobe", mac_rx_data, 0);
      else begin
        logic [5:0] e;
        e = rxq.pop_front();
        chk({mac_crs, mac_rx_er, mac_rx_data} == e, "R5/R6/R7 rx {crs,er,nib}",
            {mac_crs, mac_rx_er, mac_rx_data}, e);
      end
    end
  end

  task automatic send_nib(input logic [3:0] n);
    mac_tx_valid = 1'b1;
    mac_tx_data  = n;
    #1;
    while (!mac_tx_ready) begin
      @(negedge clk);
      #1;
    end
    for (int i = 0; i < rate(); i++) txq.push_back(n[1:0]);
    for (int i = 0; i < rate(); i++) txq.push_back(n[3:2]);
    @(negedge clk);
    chk(!mac_tx_ready, "R3 ready low after accept", mac_tx_ready, 0);
  endtask

  task automatic end_tx();
    mac_tx_valid = 1'b0;
    repeat (3 * rate() + 2) @(negedge clk);
    chk(!rmii_tx_en && rmii_txd == 0, "R8 tx idle", {rmii_tx_en, rmii_txd}, 0);
    chk(txq.size() == 0, "R2 all dibits sent", txq.size(), 0);
  endtask

  task automatic drive_dibit(input logic c, input logic [1:0] d, input logic er);
    rmii_crs_dv = c;
    rmii_rxd    = d;
    rmii_rx_er  = er;
    repeat (rate()) @(negedge clk);
  endtask

  task automatic rx_nib(input logic c_lo, input logic c_hi, input logic [3:0] n,
                        input logic er_hi);
    rxq.push_back({c_lo, er_hi, n});
    drive_dibit(c_lo, n[1:0], 1'b0);
    drive_dibit(c_hi, n[3:2], er_hi);
  endtask

  task automatic rx_preamble();
    drive_dibit(1'b0, 2'b00, 1'b0);
    drive_dibit(1'b1, 2'b01, 1'b0);
    drive_dibit(1'b1, 2'b01, 1'b0);
    chk(mac_crs == 1'b1, "R6 crs during preamble", mac_crs, 1);
    for (int i = 0; i < 5; i++) drive_dibit(1'b1, 2'b01, 1'b0);
    drive_dibit(1'b1, 2'b11, 1'b0);
  endtask

  task automatic rx_close();
    drive_dibit(1'b0, 2'b00, 1'b0);
    drive_dibit(1'b0, 2'b00, 1'b0);
    repeat (3) @(negedge clk);
    chk(mac_crs == 1'b0, "R6 crs low after frame", mac_crs, 0);
    chk(rxq.size() == 0, "R5 all nibbles received", rxq.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rmii_tx_en && !mac_rx_valid && !mac_crs, "R9 reset state",
        {rmii_tx_en, mac_rx_valid, mac_crs}, 0);

    // R1 pass-through
    cfg_rmii = 1'b0;
    mac_tx_data = 4'hA; mac_tx_valid = 1'b1; mac_tx_er = 1'b1;
    mii_rxd = 4'h6; mii_rx_dv = 1'b1; mii_rx_er = 1'b1; mii_crs = 1'b1; mii_col = 1'b1;
    #1;
    chk({mii_txd, mii_tx_en, mii_tx_er} == 6'b1010_11, "R1 tx pass",
        {mii_txd, mii_tx_en, mii_tx_er}, 6'b1010_11);
    chk({mac_rx_data, mac_rx_valid, mac_rx_er, mac_crs, mac_col} == 8'b0110_1111,
        "R1 rx pass", {mac_rx_data, mac_rx_valid, mac_rx_er, mac_crs, mac_col}, 8'b0110_1111);
    chk(mac_tx_ready == 1'b1, "R1 ready", mac_tx_ready, 1);
    @(negedge clk);
    mac_tx_valid = 1'b0; mii_rx_dv = 1'b0; mii_crs = 1'b0;
    cfg_rmii = 1'b1;
    #1;
    // R7 masking while collision and tx error present
    chk(!mac_col && !mii_tx_er && !mii_tx_en && mii_txd == 0, "R7 MII side forced off",
        {mac_col, mii_tx_er, mii_tx_en, mii_txd}, 0);
    @(negedge clk);

    // 100 Mb/s transmit
    send_nib(4'h1); send_nib(4'hE); send_nib(4'h7); send_nib(4'hC);
    end_tx();
    // 10 Mb/s transmit
    cfg_10m = 1'b1;
    @(negedge clk);
    send_nib(4'h9); send_nib(4'h6);
    end_tx();
    mac_tx_er = 1'b0; mii_col = 1'b0;

    // 100 Mb/s receive with error and carrier-drop tail
    cfg_10m = 1'b0;
    @(negedge clk);
    rx_preamble();
    rx_nib(1'b1, 1'b1, 4'h5, 1'b0);
    rx_nib(1'b1, 1'b1, 4'hA, 1'b1);
    rx_nib(1'b1, 1'b1, 4'h3, 1'b0);
    rx_nib(1'b0, 1'b1, 4'h6, 1'b0);
    rx_nib(1'b0, 1'b1, 4'h9, 1'b0);
    rx_close();

    // false carrier: no 01 dibit, no nibble expected
    drive_dibit(1'b1, 2'b10, 1'b0);
    drive_dibit(1'b1, 2'b11, 1'b0);
    drive_dibit(1'b1, 2'b00, 1'b0);
    drive_dibit(1'b1, 2'b11, 1'b0);
    drive_dibit(1'b0, 2'b00, 1'b0);
    repeat (3) @(negedge clk);
    chk(rxq.size() == 0 && !mac_rx_valid, "R5 false carrier ignored", mac_rx_valid, 0);

    // 10 Mb/s receive
    cfg_10m = 1'b1;
    @(negedge clk);
    rx_preamble();
    rx_nib(1'b1, 1'b1, 4'hB, 1'b0);
    rx_nib(1'b0, 1'b1, 4'h4, 1'b0);
    rx_close();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule